// File: doc/BRIEF.md
# Serial Word Transmitter with Parity Insertion and Self-Test Loopback

This block takes 32-bit words from a transmit FIFO and sends them out one bit at a time on a complementary output pair. Before a word goes out, its top bit can be left as it came from the FIFO or replaced by a generated parity bit. The parity sense is odd or even, selected by a configuration bit. The bit period is the system clock divided by one of two ratios: a fast ratio (10 by default) or a slow ratio (80 by default).

Every word is followed by a run of null bit periods, during which both outputs are low. The next word is fetched only when that run has ended and the FIFO holds data. In self-test mode the output pair does not reach the external line. It is routed internally to the receiver-side inputs instead, and the external line is held low.

The block also decodes the FIFO fill level into three flags: empty, full and at-least-half.

Top module: `tx_word_serializer`

## Requirements
- R1: The cycle after a fetch, the word starts on the pair. Word bit 0 goes first and word bit 31 goes last. Each bit holds for one whole bit period.
- R2: With parity insertion off, the 32nd transmitted bit equals bit 31 of the word as read from the FIFO.
- R3: With parity insertion on, the 32nd transmitted bit replaces bit 31 so that all 32 transmitted bits contain an odd number of ones when the sense bit is 0, or an even number when it is 1. Bits 0 to 30 are never altered.
- R4: The bit period is FAST_DIV clocks when the rate bit is 0 and SLOW_DIV clocks when it is 1. The rate and parity settings are taken in the fetch cycle. Changing them later does not alter the word in flight.
- R5: While a bit is being sent, the high output carries the bit value and the low output carries its inverse. At all other times both outputs are low. They are never high together.
- R6: After the last data bit, GAP_BITS bit periods of null follow. The block then returns to idle. The FIFO read strobe is a single-cycle pulse raised only in idle, and the word on the FIFO data input is taken in that cycle. With the FIFO kept non-empty, consecutive strobes are exactly (32 + GAP_BITS) × period + 1 clocks apart.
- R7: The read strobe is never raised while the FIFO level is 0. With an empty FIFO the block stays idle with both outputs low.
- R8: With loopback on, the external line outputs are both low and the receiver-side outputs carry the transmitted pair. With loopback off, the line outputs carry the pair and the receiver-side outputs follow the external receive inputs. The switch takes effect in the same cycle.
- R9: The empty flag is high when the level is 0. The full flag is high when the level equals FIFO_DEPTH. The half flag is high when the level is at least HALF_MARK.
- R10: During and right after reset, the block is idle, both pairs are low and no read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LVL_W | Number of words held in the transmit FIFO |
| fifo_data | input | WORD_W | Head word of the FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pop strobe; head word taken this cycle |
| cfg_par_en | input | 1 | 1: replace bit 31 by a parity bit |
| cfg_par_even | input | 1 | Parity sense: 0 odd, 1 even |
| cfg_slow | input | 1 | Rate: 0 fast divider, 1 slow divider |
| cfg_loop | input | 1 | 1: self-test loopback |
| ext_rx_hi | input | 1 | External receive line, high leg |
| ext_rx_lo | input | 1 | External receive line, low leg |
| line_hi | output | 1 | Transmit line, high leg |
| line_lo | output | 1 | Transmit line, low leg |
| rx_hi | output | 1 | Receiver-side input, high leg |
| rx_lo | output | 1 | Receiver-side input, low leg |
| st_empty | output | 1 | FIFO empty flag |
| st_half | output | 1 | FIFO at-least-half flag |
| st_full | output | 1 | FIFO full flag |

## Verification
The bench builds the block with FAST_DIV=2, SLOW_DIV=5, GAP_BITS=4, FIFO_DEPTH=8 and HALF_MARK=4.

The short dividers keep each word to well under two hundred clocks. This leaves room for bursts at both rates, mid-word changes of rate, parity and loopback, and exact strobe spacing checks. A depth of eight lets a single burst of pushes drive the level through full, half and empty while the reference model follows every cycle.

// File: rtl/txfmt_pkg.sv
`timescale 1ns/1ps
package txfmt_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_NULL = 2'd2
   } tx_phase_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/txfmt_word_builder.sv
`timescale 1ns/1ps
module txfmt_word_builder #(
   parameter int unsigned WORD_W    = 32,
   parameter bit          PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] raw_word,
   input  logic              par_en,
   input  logic              par_even,
   output logic [WORD_W-1:0] word_out
);

   if (WORD_W < 2) begin : g_bad_width
      $error("txfmt_word_builder: WORD_W must be at least 2");
   end

   generate
      if (PARITY_EN) begin : g_parity
         logic [WORD_W-2:0] body;
         logic              gen_bit;

         assign body    = raw_word[WORD_W-2:0];
         // odd sense sets the bit when the body count is even
         assign gen_bit = (^body) ^ ~par_even;
         assign word_out = par_en ? {gen_bit, body} : raw_word;

         // R3
         odd_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (par_en && !par_even) |-> (^word_out == 1'b1));
         // R3
         even_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (par_en && par_even) |-> (^word_out == 1'b0));
      end else begin : g_plain
         logic unused_cfg;
         assign unused_cfg = par_en ^ par_even;
         assign word_out   = raw_word;
      end
   endgenerate

   // R3
   body_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_out[WORD_W-2:0] == raw_word[WORD_W-2:0]);

endmodule

// File: rtl/txfmt_bit_timer.sv
`timescale 1ns/1ps
module txfmt_bit_timer
   import txfmt_pkg::*;
#(
   parameter int unsigned FAST_DIV = 10,
   parameter int unsigned SLOW_DIV = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic slow_sel,
   output logic tick
);

   localparam int unsigned CNT_W = cnt_width(SLOW_DIV);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   generate
      if (SLOW_DIV == FAST_DIV) begin : g_single
         logic unused_sel;
         assign unused_sel = slow_sel;
         assign last_val   = CNT_W'(FAST_DIV - 1);
      end else begin : g_dual
         logic slow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slow_q <= 1'b0;
            else if (restart) slow_q <= slow_sel;
         end
         assign last_val = slow_q ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
      end
   endgenerate

   assign tick = (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || tick)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SLOW_DIV - 1));

   // R4
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/txfmt_serializer.sv
`timescale 1ns/1ps
module txfmt_serializer
   import txfmt_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned GAP_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have_word,
   input  logic [WORD_W-1:0] word_in,
   input  logic              tick,
   output logic              fetch,
   output logic              drv_hi,
   output logic              drv_lo
);

   localparam int unsigned IDX_MAX = (WORD_W > GAP_BITS) ? WORD_W : GAP_BITS;
   localparam int unsigned IDX_W   = cnt_width(IDX_MAX);
   localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(WORD_W - 1);
   localparam logic [IDX_W-1:0] LAST_GAP = IDX_W'(GAP_BITS - 1);

   tx_phase_e         phase_q;
   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic              in_data;

   assign fetch   = (phase_q == PH_IDLE) && have_word;
   assign in_data = (phase_q == PH_DATA);
   assign drv_hi  = in_data &  sh_q[0];
   assign drv_lo  = in_data & ~sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sh_q    <= '0;
         idx_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (have_word) begin
                  sh_q    <= word_in;
                  idx_q   <= '0;
                  phase_q <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (tick) begin
                  sh_q <= sh_q >> 1;
                  if (idx_q == LAST_BIT) begin
                     idx_q   <= '0;
                     phase_q <= PH_NULL;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            PH_NULL: begin
               if (tick) begin
                  if (idx_q == LAST_GAP) phase_q <= PH_IDLE;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // R5
   pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_hi && drv_lo));
   // R6
   fetch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> !fetch);
   // R1
   data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> (drv_hi || drv_lo));

endmodule

// File: rtl/txfmt_line_route.sv
`timescale 1ns/1ps
module txfmt_line_route (
   input  logic loop_sel,
   input  logic drv_hi,
   input  logic drv_lo,
   input  logic ext_hi,
   input  logic ext_lo,
   output logic line_hi,
   output logic line_lo,
   output logic rx_hi,
   output logic rx_lo
);

   always_comb begin
      if (loop_sel) begin
         line_hi = 1'b0;
         line_lo = 1'b0;
         rx_hi   = drv_hi;
         rx_lo   = drv_lo;
      end else begin
         line_hi = drv_hi;
         line_lo = drv_lo;
         rx_hi   = ext_hi;
         rx_lo   = ext_lo;
      end
   end

endmodule

// File: rtl/tx_word_serializer.sv
`timescale 1ns/1ps
module tx_word_serializer #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned FAST_DIV   = 10,
   parameter int unsigned SLOW_DIV   = 80,
   parameter int unsigned GAP_BITS   = 4,
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned HALF_MARK  = 16,
   parameter bit          PARITY_EN  = 1'b1,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [WORD_W-1:0] fifo_data,
   output logic              fifo_rd,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              cfg_slow,
   input  logic              cfg_loop,
   input  logic              ext_rx_hi,
   input  logic              ext_rx_lo,
   output logic              line_hi,
   output logic              line_lo,
   output logic              rx_hi,
   output logic              rx_lo,
   output logic              st_empty,
   output logic              st_half,
   output logic              st_full
);

   if (FAST_DIV < 2) begin : g_bad_fast
      $error("tx_word_serializer: FAST_DIV must be at least 2");
   end
   if (SLOW_DIV < FAST_DIV) begin : g_bad_slow
      $error("tx_word_serializer: SLOW_DIV must not be below FAST_DIV");
   end
   if (GAP_BITS < 1) begin : g_bad_gap
      $error("tx_word_serializer: GAP_BITS must be at least 1");
   end
   if (HALF_MARK > FIFO_DEPTH || FIFO_DEPTH < 1) begin : g_bad_depth
      $error("tx_word_serializer: HALF_MARK must lie within FIFO_DEPTH");
   end
   if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl
      $error("tx_word_serializer: LVL_W too narrow for FIFO_DEPTH");
   end

   logic [WORD_W-1:0] built_word;
   logic              have_word;
   logic              bit_tick;
   logic              drv_hi;
   logic              drv_lo;

   assign have_word = (fifo_level != '0);

   txfmt_word_builder #(
      .WORD_W    (WORD_W),
      .PARITY_EN (PARITY_EN)
   ) u_builder (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_word (fifo_data),
      .par_en   (cfg_par_en),
      .par_even (cfg_par_even),
      .word_out (built_word)
   );

   txfmt_bit_timer #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (fifo_rd),
      .slow_sel (cfg_slow),
      .tick     (bit_tick)
   );

   txfmt_serializer #(
      .WORD_W   (WORD_W),
      .GAP_BITS (GAP_BITS)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .have_word (have_word),
      .word_in   (built_word),
      .tick      (bit_tick),
      .fetch     (fifo_rd),
      .drv_hi    (drv_hi),
      .drv_lo    (drv_lo)
   );

   txfmt_line_route u_route (
      .loop_sel (cfg_loop),
      .drv_hi   (drv_hi),
      .drv_lo   (drv_lo),
      .ext_hi   (ext_rx_hi),
      .ext_lo   (ext_rx_lo),
      .line_hi  (line_hi),
      .line_lo  (line_lo),
      .rx_hi    (rx_hi),
      .rx_lo    (rx_lo)
   );

   assign st_empty = (fifo_level == '0);
   assign st_full  = (fifo_level == LVL_W'(FIFO_DEPTH));
   assign st_half  = (fifo_level >= LVL_W'(HALF_MARK));

   // R7
   rd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == '0) |-> !fifo_rd);
   // R8
   loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_loop |-> (!line_hi && !line_lo));
   // R9
   full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_full |-> (st_half && !st_empty));

endmodule

// File: tb/tx_word_serializer_tb.sv
`timescale 1ns/1ps
module tx_word_serializer_tb;

   localparam int WORD_W = 32;
   localparam int FAST   = 2;
   localparam int SLOW   = 5;
   localparam int GAP    = 4;
   localparam int DEPTH  = 8;
   localparam int HALF   = 4;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LVL_W-1:0]  fifo_level = '0;
   logic [WORD_W-1:0] fifo_data = '0;
   logic              fifo_rd;
   logic              cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_slow = 1'b0, cfg_loop = 1'b0;
   logic              ext_rx_hi = 1'b0, ext_rx_lo = 1'b1;
   logic              line_hi, line_lo, rx_hi, rx_lo, st_empty, st_half, st_full;

   always #2 clk = ~clk;

   tx_word_serializer #(
      .WORD_W(WORD_W), .FAST_DIV(FAST), .SLOW_DIV(SLOW), .GAP_BITS(GAP),
      .FIFO_DEPTH(DEPTH), .HALF_MARK(HALF), .PARITY_EN(1'b1), .LVL_W(LVL_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_data(fifo_data),
      .fifo_rd(fifo_rd), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_slow(cfg_slow), .cfg_loop(cfg_loop), .ext_rx_hi(ext_rx_hi),
      .ext_rx_lo(ext_rx_lo), .line_hi(line_hi), .line_lo(line_lo),
      .rx_hi(rx_hi), .rx_lo(rx_lo), .st_empty(st_empty), .st_half(st_half),
      .st_full(st_full)
   );

   int checks = 0;
   int errors = 0;
   bit tb_done = 1'b0;
   int cyc = 0;
   logic [WORD_W-1:0] q[$];

   // reference model state
   bit                ref_busy = 1'b0;
   int                ref_k = 0;
   int                ref_d = FAST;
   logic [WORD_W-1:0] ref_word = '0;
   logic [WORD_W-1:0] ref_raw = '0;
   bit                ref_pe = 1'b0;
   bit                ref_ev = 1'b0;

   // strobe spacing bookkeeping
   bit have_prev = 1'b0;
   bit prev_more = 1'b0;
   int prev_rd = 0;
   int prev_d = FAST;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   function automatic logic [WORD_W-1:0] shape(input logic [WORD_W-1:0] w, input bit pe, input bit ev);
      int ones;
      logic pbit;
      ones = $countones(w[WORD_W-2:0]);
      if (!pe) return w;
      if (ev) pbit = (ones % 2 == 1);
      else    pbit = (ones % 2 == 0);
      return {pbit, w[WORD_W-2:0]};
   endfunction

   // external receive legs toggle on their own
   always @(posedge clk) begin
      if (cyc % 3 == 0) begin
         ext_rx_hi <= ~ext_rx_hi;
         ext_rx_lo <= ext_rx_hi;
      end
   end

   // FIFO model and reference advance
   always @(posedge clk) begin
      if (!rst_n) begin
         ref_busy = 1'b0;
         ref_k    = 0;
         fifo_level <= '0;
         fifo_data  <= '0;
      end else begin
         cyc++;
         if (!ref_busy) begin
            if (fifo_level != '0) begin
               ref_raw  = q[0];
               ref_pe   = cfg_par_en;
               ref_ev   = cfg_par_even;
               ref_word = shape(q[0], cfg_par_en, cfg_par_even);
               ref_d    = cfg_slow ? SLOW : FAST;
               ref_k    = 0;
               ref_busy = 1'b1;
               void'(q.pop_front());
            end
         end else begin
            ref_k++;
            if (ref_k == (WORD_W + GAP) * ref_d) ref_busy = 1'b0;
         end
         fifo_level <= LVL_W'(q.size());
         fifo_data  <= (q.size() > 0) ? q[0] : '0;
      end
   end

   // compare on the falling edge
   always @(negedge clk) begin
      if (rst_n && !tb_done) begin
         logic exp_rd, p_hi, p_lo, exp_bit, obs;
         p_hi = 1'b0;
         p_lo = 1'b0;
         if (!ref_busy) begin
            exp_rd = (fifo_level != '0);
         end else begin
            exp_rd = 1'b0;
            if (ref_k < WORD_W * ref_d) begin
               p_hi = ref_word[ref_k / ref_d];
               p_lo = ~p_hi;
            end
         end
         chk(fifo_rd == exp_rd, "R6 R7", "fifo_rd", 32'(fifo_rd), 32'(exp_rd));
         chk(line_hi == (cfg_loop ? 1'b0 : p_hi), "R1 R4 R5 R8", "line_hi", 32'(line_hi), 32'(cfg_loop ? 1'b0 : p_hi));
         chk(line_lo == (cfg_loop ? 1'b0 : p_lo), "R5 R8", "line_lo", 32'(line_lo), 32'(cfg_loop ? 1'b0 : p_lo));
         chk(rx_hi == (cfg_loop ? p_hi : ext_rx_hi), "R8", "rx_hi", 32'(rx_hi), 32'(cfg_loop ? p_hi : ext_rx_hi));
         chk(rx_lo == (cfg_loop ? p_lo : ext_rx_lo), "R8", "rx_lo", 32'(rx_lo), 32'(cfg_loop ? p_lo : ext_rx_lo));
         chk(st_empty == (fifo_level == 0), "R9", "st_empty", 32'(st_empty), 32'(fifo_level == 0));
         chk(st_full == (fifo_level == DEPTH), "R9", "st_full", 32'(st_full), 32'(fifo_level == DEPTH));
         chk(st_half == (fifo_level >= HALF), "R9", "st_half", 32'(st_half), 32'(fifo_level >= HALF));

         // 32nd bit, checked against the rule directly
         if (ref_busy && ref_k == (WORD_W - 1) * ref_d) begin
            obs = cfg_loop ? rx_hi : line_hi;
            if (ref_pe) begin
               exp_bit = ref_ev ? ($countones(ref_raw[WORD_W-2:0]) % 2 == 1)
                                : ($countones(ref_raw[WORD_W-2:0]) % 2 == 0);
               chk(obs == exp_bit, "R3", "parity bit", 32'(obs), 32'(exp_bit));
            end else begin
               exp_bit = ref_raw[WORD_W-1];
               chk(obs == exp_bit, "R2", "plain bit 32", 32'(obs), 32'(exp_bit));
            end
         end

         // strobe spacing
         if (fifo_rd) begin
            if (have_prev) begin
               chk(cyc - prev_rd >= (WORD_W + GAP) * prev_d + 1, "R6", "strobe gap min",
                   32'(cyc - prev_rd), 32'((WORD_W + GAP) * prev_d + 1));
               if (prev_more)
                  chk(cyc - prev_rd == (WORD_W + GAP) * prev_d + 1, "R4 R6", "strobe gap exact",
                      32'(cyc - prev_rd), 32'((WORD_W + GAP) * prev_d + 1));
            end
            have_prev = 1'b1;
            prev_rd   = cyc;
            prev_d    = cfg_slow ? SLOW : FAST;
            prev_more = (fifo_level > 1);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_idle();
      while (q.size() != 0 || ref_busy || fifo_level != '0) @(posedge clk);
      #1;
      have_prev = 1'b0;
   endtask

   initial begin
      // R10: reset state
      step(3);
      @(negedge clk);
      chk(!fifo_rd && !line_hi && !line_lo, "R10", "reset outputs", {29'd0, fifo_rd, line_hi, line_lo}, 32'd0);
      chk(st_empty == 1'b1, "R10", "reset empty flag", 32'(st_empty), 32'd1);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!fifo_rd && !line_hi && !line_lo, "R10", "after reset", {29'd0, fifo_rd, line_hi, line_lo}, 32'd0);

      // R7: empty FIFO stays idle
      step(12);

      // R9 / R2: burst to full, parity off
      step(1);
      q.push_back(32'h8000_0001); q.push_back(32'h0000_0003);
      q.push_back(32'hFFFF_FFFF); q.push_back(32'h7FFF_FFFE);
      q.push_back(32'hA5A5_5A5A); q.push_back(32'h0000_0000);
      q.push_back(32'h8000_0000); q.push_back(32'h1234_5678);
      @(negedge clk); @(negedge clk);
      chk(st_full && st_half && !st_empty, "R9", "full after burst",
          {29'd0, st_full, st_half, st_empty}, 32'd6);
      wait_idle();

      // R3: odd parity
      cfg_par_en = 1'b1; cfg_par_even = 1'b0;
      q.push_back(32'h0000_0001); q.push_back(32'hFFFF_FFFF); q.push_back(32'h8000_0000);
      wait_idle();

      // R3: even parity
      cfg_par_even = 1'b1;
      q.push_back(32'h0000_0001); q.push_back(32'h7FFF_FFFF); q.push_back(32'h0F0F_0F0E);
      wait_idle();

      // R4: slow rate, settings changed mid-word
      cfg_slow = 1'b1;
      q.push_back(32'hDEAD_BEEF); q.push_back(32'h0123_4567);
      step(25);
      cfg_slow = 1'b0; cfg_par_even = 1'b0; cfg_par_en = 1'b0;
      wait_idle();

      // R8: loopback, switched off mid-word
      cfg_loop = 1'b1; cfg_par_en = 1'b1;
      q.push_back(32'hCAFE_F00D); q.push_back(32'h5555_AAAA);
      step(30);
      cfg_loop = 1'b0;
      step(40);
      cfg_loop = 1'b1;
      wait_idle();
      cfg_loop = 1'b0;
      step(10);

      tb_done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!tb_done) begin
         tb_done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule